// File: doc/BRIEF.md
# APB to Debug Bus Bridge

The bridge connects a 32-bit APB slave port to a 34-bit debug bus that reaches a processor's debug module. The debug word is two bits wider than APB can carry in one access. It is therefore built in a 34-bit staging register. Software writes the low 32 bits at one address and the two upper bits at another. A write to the command register then launches one debug bus read or write at a chosen debug register address. Of the two upper bits, bit 32 is the interrupt notification and bit 33 is the halt notification. The same two bits are also mirrored in a control register, so software that only ever uses the low word can still read and set them.

Each debug bus transaction is a request followed by a response, and both use a valid/ready handshake. For a write, the request carries the full staging word. For a read, the 34-bit response overwrites the staging register. Software polls the status register for busy and error. If the parameter `NOTIFY_IMPL` is 0, no storage is built for the notification bits: they always read as zero and the bus carries zero in bits 33:32.

Top module: `apb_dbg_bridge`

## Requirements
- R1: After reset all registers read zero, busy is 0, `dbg_req_valid_o` and `dbg_rsp_ready_o` are low, and `pready_o` is always 1.
- R2: Offset 0x00 reads and writes staging bits [31:0]. Offset 0x04 reads and writes staging bits [33:32] in its bits [1:0], and all other bits of 0x04 read zero.
- R3: Offset 0x10 is the notification control register: bit 0 is the interrupt bit (staging bit 32) and bit 1 is the halt bit (staging bit 33). A write through 0x04 or 0x10 is visible at the other offset.
- R4: A write to the command register at 0x08 while idle (address in bits [4:0], write flag in bit 8) raises exactly one request carrying that address and flag. Status bit 0 (busy) is set from the next cycle until the response is taken. Reading 0x08 returns the stored command.
- R5: A write transaction presents the full 34-bit staging value on `dbg_req_data_o`, and the staging register is unchanged when it completes.
- R6: While `dbg_req_valid_o` is high and `dbg_req_ready_i` is low, the request stays asserted and its address, flag and data do not change.
- R7: After a request is accepted, `dbg_rsp_ready_o` is high until a response arrives. A response to a read loads all 34 bits into the staging register in the same cycle that busy clears.
- R8: While busy, an APB write to 0x00, 0x04, 0x08 or 0x10 changes no state, drives `pslverr_o` high in its access phase, and sets status bit 1 (error). Writing status with bit 1 set clears the error. Reads during busy complete without error.
- R9: With `NOTIFY_IMPL` = 0, offsets 0x04 and 0x10 read zero, writes to them have no effect, and request bits 33:32 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | PADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error for a write rejected while busy |
| dbg_req_valid_o | output | 1 | Debug request valid |
| dbg_req_ready_i | input | 1 | Debug request accepted |
| dbg_req_addr_o | output | DADDR_W | Debug register address |
| dbg_req_write_o | output | 1 | 1 = write, 0 = read |
| dbg_req_data_o | output | 34 | Debug write word |
| dbg_rsp_valid_i | input | 1 | Debug response valid |
| dbg_rsp_data_i | input | 34 | Debug response word |
| dbg_rsp_ready_o | output | 1 | Bridge is waiting for a response |

## Verification
The bench holds the request unaccepted for several cycles and checks that address, flag and data stay frozen. A bridge that sampled the live registers without blocking writes would show a changed request there. While busy, it writes the staging and command registers and reads them back. A design that let those writes through would show the new values, raise no PSLVERR, or launch a second request. For the read path, the bench returns a word with nonzero upper bits and reads both halves and the control mirror. A bridge that dropped bits 33:32, or mixed up the interrupt and halt positions, fails those reads. A second instance built without notification storage takes the same stimulus and must return zero in the upper bits.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int APB_W  = 32;
  localparam int NOTE_W = 2;
  localparam int WORD_W = APB_W + NOTE_W;

  localparam int CMD_WR_BIT = 8;
  localparam int ST_BUSY    = 0;
  localparam int ST_ERR     = 1;

  localparam logic [7:0] OFS_LO   = 8'h00;
  localparam logic [7:0] OFS_HI   = 8'h04;
  localparam logic [7:0] OFS_CMD  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } bus_st_e;
endpackage

// File: rtl/dbb_apb_regs.sv
module dbb_apb_regs
  import dbb_pkg::*;
#(
  parameter int PADDR_W     = 8,
  parameter int DADDR_W     = 5,
  parameter bit NOTIFY_IMPL = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [PADDR_W-1:0] paddr_i,
  input  logic [APB_W-1:0]   pwdata_i,
  output logic [APB_W-1:0]   prdata_o,
  output logic               pslverr_o,
  input  logic               busy_i,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  load_data_i,
  output logic               start_o,
  output logic [DADDR_W-1:0] cmd_addr_o,
  output logic               cmd_write_o,
  output logic [WORD_W-1:0]  stage_o
);
  logic sel_lo, sel_hi, sel_cmd, sel_stat, sel_ctrl;
  logic wr, wr_ok, guarded, reject;
  logic [APB_W-1:0]   lo_q;
  logic [NOTE_W-1:0]  note_q;
  logic [DADDR_W-1:0] cmd_addr_q;
  logic               cmd_wr_q;
  logic               err_q;

  assign sel_lo   = paddr_i == PADDR_W'(OFS_LO);
  assign sel_hi   = paddr_i == PADDR_W'(OFS_HI);
  assign sel_cmd  = paddr_i == PADDR_W'(OFS_CMD);
  assign sel_stat = paddr_i == PADDR_W'(OFS_STAT);
  assign sel_ctrl = paddr_i == PADDR_W'(OFS_CTRL);

  assign wr      = psel_i & penable_i & pwrite_i;
  assign guarded = sel_lo | sel_hi | sel_cmd | sel_ctrl;
  assign reject  = wr & guarded & busy_i;
  assign wr_ok   = wr & ~busy_i;

  assign pslverr_o = reject;
  assign start_o   = wr_ok & sel_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lo_q <= '0;
    else if (load_i)            lo_q <= load_data_i[APB_W-1:0];
    else if (wr_ok && sel_lo)   lo_q <= pwdata_i;
  end

  generate
    if (NOTIFY_IMPL) begin : g_note
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          note_q <= '0;
        else if (load_i)                      note_q <= load_data_i[WORD_W-1:APB_W];
        else if (wr_ok && (sel_hi || sel_ctrl)) note_q <= pwdata_i[NOTE_W-1:0];
      end
    end else begin : g_tie
      logic unused_hi;
      assign unused_hi = ^load_data_i[WORD_W-1:APB_W];
      assign note_q    = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_addr_q <= '0;
      cmd_wr_q   <= 1'b0;
    end else if (start_o) begin
      cmd_addr_q <= pwdata_i[DADDR_W-1:0];
      cmd_wr_q   <= pwdata_i[CMD_WR_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                err_q <= 1'b0;
    else if (reject)                            err_q <= 1'b1;
    else if (wr && sel_stat && pwdata_i[ST_ERR]) err_q <= 1'b0;
  end

  assign stage_o     = {note_q, lo_q};
  assign cmd_addr_o  = cmd_addr_q;
  assign cmd_write_o = cmd_wr_q;

  always_comb begin
    prdata_o = '0;
    if (sel_lo) prdata_o = lo_q;
    if (sel_hi || sel_ctrl) prdata_o[NOTE_W-1:0] = note_q;
    if (sel_cmd) begin
      prdata_o[DADDR_W-1:0] = cmd_addr_q;
      prdata_o[CMD_WR_BIT]  = cmd_wr_q;
    end
    if (sel_stat) begin
      prdata_o[ST_BUSY] = busy_i;
      prdata_o[ST_ERR]  = err_q;
    end
  end

  // R8
  rejected_keeps_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject && !load_i |=> $stable(stage_o));
  // R8
  rejected_keeps_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> $stable(cmd_addr_q) && $stable(cmd_wr_q));
  // R8
  rejected_sets_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> err_q);
endmodule

// File: rtl/dbb_bus_ctrl.sv
module dbb_bus_ctrl
  import dbb_pkg::*;
#(
  parameter int DADDR_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DADDR_W-1:0] cmd_addr_i,
  input  logic               cmd_write_i,
  input  logic [WORD_W-1:0]  stage_i,
  output logic               busy_o,
  output logic               load_o,
  output logic [WORD_W-1:0]  load_data_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [DADDR_W-1:0] req_addr_o,
  output logic               req_write_o,
  output logic [WORD_W-1:0]  req_data_o,
  input  logic               rsp_valid_i,
  input  logic [WORD_W-1:0]  rsp_data_i,
  output logic               rsp_ready_o
);
  bus_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_i)     st_d = ST_REQ;
      ST_REQ:  if (req_ready_i) st_d = ST_RSP;
      ST_RSP:  if (rsp_valid_i) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o      = st_q != ST_IDLE;
  assign req_valid_o = st_q == ST_REQ;
  assign rsp_ready_o = st_q == ST_RSP;
  // command and staging are write-protected while busy, so drive them directly
  assign req_addr_o  = cmd_addr_i;
  assign req_write_o = cmd_write_i;
  assign req_data_o  = stage_i;
  assign load_o      = rsp_ready_o & rsp_valid_i & ~cmd_write_i;
  assign load_data_o = rsp_data_i;

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_write_o) && $stable(req_data_o));
  // R4
  start_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R4
  one_req_per_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(start_i));
  // R7
  rsp_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> rsp_ready_o);
endmodule

// File: rtl/apb_dbg_bridge.sv
module apb_dbg_bridge
  import dbb_pkg::*;
#(
  parameter int PADDR_W     = 8,
  parameter int DADDR_W     = 5,
  parameter bit NOTIFY_IMPL = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [PADDR_W-1:0] paddr_i,
  input  logic [31:0]        pwdata_i,
  output logic [31:0]        prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  output logic               dbg_req_valid_o,
  input  logic               dbg_req_ready_i,
  output logic [DADDR_W-1:0] dbg_req_addr_o,
  output logic               dbg_req_write_o,
  output logic [33:0]        dbg_req_data_o,
  input  logic               dbg_rsp_valid_i,
  input  logic [33:0]        dbg_rsp_data_i,
  output logic               dbg_rsp_ready_o
);
  logic               busy, load, start, cmd_write;
  logic [WORD_W-1:0]  load_data, stage;
  logic [DADDR_W-1:0] cmd_addr;

  assign pready_o = 1'b1;

  dbb_apb_regs #(
    .PADDR_W(PADDR_W), .DADDR_W(DADDR_W), .NOTIFY_IMPL(NOTIFY_IMPL)
  ) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o, .pslverr_o,
    .busy_i(busy), .load_i(load), .load_data_i(load_data),
    .start_o(start), .cmd_addr_o(cmd_addr), .cmd_write_o(cmd_write),
    .stage_o(stage)
  );

  dbb_bus_ctrl #(.DADDR_W(DADDR_W)) u_bus (
    .clk_i, .rst_ni,
    .start_i(start), .cmd_addr_i(cmd_addr), .cmd_write_i(cmd_write),
    .stage_i(stage), .busy_o(busy), .load_o(load), .load_data_o(load_data),
    .req_valid_o(dbg_req_valid_o), .req_ready_i(dbg_req_ready_i),
    .req_addr_o(dbg_req_addr_o), .req_write_o(dbg_req_write_o),
    .req_data_o(dbg_req_data_o),
    .rsp_valid_i(dbg_rsp_valid_i), .rsp_data_i(dbg_rsp_data_i),
    .rsp_ready_o(dbg_rsp_ready_o)
  );
endmodule

// File: tb/apb_dbg_bridge_tb.sv
module apb_dbg_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic        req_ready = 0, rsp_valid = 0;
  logic [33:0] rsp_data = '0;

  logic [31:0] prdata, prdata_t;
  logic        pready, pready_t, pslverr, pslverr_t;
  logic        req_valid, req_valid_t, req_write, req_write_t;
  logic [4:0]  req_addr, req_addr_t;
  logic [33:0] req_data, req_data_t;
  logic        rsp_ready, rsp_ready_t;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_dbg_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .dbg_req_valid_o(req_valid), .dbg_req_ready_i(req_ready),
    .dbg_req_addr_o(req_addr), .dbg_req_write_o(req_write),
    .dbg_req_data_o(req_data), .dbg_rsp_valid_i(rsp_valid),
    .dbg_rsp_data_i(rsp_data), .dbg_rsp_ready_o(rsp_ready)
  );

  apb_dbg_bridge #(.NOTIFY_IMPL(1'b0)) u_dut_tied (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata_t), .pready_o(pready_t), .pslverr_o(pslverr_t),
    .dbg_req_valid_o(req_valid_t), .dbg_req_ready_i(req_ready),
    .dbg_req_addr_o(req_addr_t), .dbg_req_write_o(req_write_t),
    .dbg_req_data_o(req_data_t), .dbg_rsp_valid_i(rsp_valid),
    .dbg_rsp_data_i(rsp_data), .dbg_rsp_ready_o(rsp_ready_t)
  );

  typedef struct {
    logic [31:0] exp;
    logic [31:0] exp_t;
    string       tag;
  } sb_item_t;
  sb_item_t    sb_q[$];
  logic [31:0] got, got_t;
  event        rd_ev;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each completed read against the queued expectation
  initial forever begin
    sb_item_t it;
    @(rd_ev);
    it = sb_q.pop_front();
    chk(got == it.exp, it.tag, 64'(got), 64'(it.exp));
    chk(got_t == it.exp_t, {it.tag, " tied R9"}, 64'(got_t), 64'(it.exp_t));
  end

  task automatic apb_read(input logic [7:0] a, input logic [31:0] e,
                          input logic [31:0] et, input string tag);
    sb_q.push_back('{exp: e, exp_t: et, tag: tag});
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1;
    got = prdata; got_t = prdata_t;
    chk(!pslverr, {tag, " read no err R8"}, 64'(pslverr), 0);
    ->rd_ev;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d,
                           input bit exp_err, input string tag);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    #1;
    chk(pslverr == exp_err && pslverr_t == exp_err, tag, 64'(pslverr), 64'(exp_err));
    chk(pready && pready_t, "pready high R1", 64'(pready), 1);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  // debug bus responder; called at a negedge while the request is pending
  task automatic serve(input int hold, input logic [4:0] ea, input bit ew,
                       input logic [33:0] ed, input logic [33:0] edt,
                       input logic [33:0] rd);
    for (int i = 0; i < hold; i++) begin
      chk(req_valid && req_addr == ea && req_write == ew && req_data == ed,
          "request held R6", {req_valid, req_write, req_addr, 23'd0, req_data[33:32]},
          {1'b1, ew, ea, 23'd0, ed[33:32]});
      chk(req_data == ed, "request data R5", 64'(req_data), 64'(ed));
      chk(req_data_t == edt, "tied request data R9", 64'(req_data_t), 64'(edt));
      @(negedge clk);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk(!req_valid && rsp_ready, "rsp ready after accept R7",
        {62'd0, req_valid, rsp_ready}, 64'd1);
    rsp_valid = 1; rsp_data = rd;
    @(negedge clk);
    rsp_valid = 0; rsp_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!req_valid && !rsp_ready && pready, "reset idle R1",
        {61'd0, req_valid, rsp_ready, pready}, 64'd1);
    apb_read(8'h00, 0, 0, "reset lo R1");
    apb_read(8'h04, 0, 0, "reset hi R1");
    apb_read(8'h08, 0, 0, "reset cmd R1");
    apb_read(8'h0C, 0, 0, "reset status R1");
    apb_read(8'h10, 0, 0, "reset ctrl R1");

    // R2 R3
    apb_write(8'h00, 32'hA5A5_1234, 0, "write lo R2");
    apb_write(8'h04, 32'hFFFF_FFFD, 0, "write hi R2");
    apb_read(8'h00, 32'hA5A5_1234, 32'hA5A5_1234, "lo readback R2");
    apb_read(8'h04, 32'h1, 32'h0, "hi readback R2");
    apb_read(8'h10, 32'h1, 32'h0, "ctrl shows interrupt bit R3");
    apb_write(8'h10, 32'h2, 0, "write ctrl R3");
    apb_read(8'h04, 32'h2, 32'h0, "hi shows halt bit R3");
    apb_write(8'h04, 32'h3, 0, "write hi both R2");

    // R4 R5 R6 R8: write transaction, request held off
    apb_write(8'h08, 32'h0000_0111, 0, "cmd write launch R4");
    chk(req_valid && req_addr == 5'h11 && req_write, "request raised R4",
        {57'd0, req_valid, req_write, req_addr}, {57'd0, 2'b11, 5'h11});
    apb_read(8'h0C, 32'h1, 32'h1, "busy set R4");
    apb_read(8'h08, 32'h111, 32'h111, "cmd readback R4");
    apb_write(8'h00, 32'h0, 1, "lo write while busy R8");
    apb_write(8'h08, 32'h0000_0005, 1, "cmd write while busy R8");
    apb_write(8'h10, 32'h0, 1, "ctrl write while busy R8");
    apb_read(8'h00, 32'hA5A5_1234, 32'hA5A5_1234, "lo unchanged while busy R8");
    apb_read(8'h04, 32'h3, 32'h0, "hi unchanged while busy R8");
    apb_read(8'h0C, 32'h3, 32'h3, "busy and error R8");
    serve(3, 5'h11, 1'b1, {2'b11, 32'hA5A5_1234}, {2'b00, 32'hA5A5_1234},
          34'h1_0BAD_0BAD);
    apb_read(8'h0C, 32'h2, 32'h2, "busy cleared error kept R8");
    apb_read(8'h00, 32'hA5A5_1234, 32'hA5A5_1234, "stage kept after write R5");
    apb_read(8'h04, 32'h3, 32'h0, "hi kept after write R5");
    apb_write(8'h0C, 32'h2, 0, "error clear R8");
    apb_read(8'h0C, 32'h0, 32'h0, "error cleared R8");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_valid && !rsp_ready, "single request R4",
          {62'd0, req_valid, rsp_ready}, 0);
    end

    // R7 R9: read transaction, immediate accept
    apb_write(8'h08, 32'h0000_0004, 0, "cmd read launch R4");
    chk(req_valid && req_addr == 5'h04 && !req_write, "read request R4",
        {57'd0, req_valid, req_write, req_addr}, {57'd0, 2'b10, 5'h04});
    serve(0, 5'h04, 1'b0, {2'b11, 32'hA5A5_1234}, {2'b00, 32'hA5A5_1234},
          34'h2_DEAD_BEEF);
    apb_read(8'h0C, 32'h0, 32'h0, "idle after read R7");
    apb_read(8'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "read data lo R7");
    apb_read(8'h04, 32'h2, 32'h0, "read data hi R7");
    apb_read(8'h10, 32'h2, 32'h0, "read data ctrl mirror R3");

    #1;
    chk(sb_q.size() == 0, "scoreboard drained", 64'(sb_q.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule